// File: doc/BRIEF.md
# Interleaved Line Fetch Controller

This block brings one cache line in from a main memory that is split into four banks. A start pulse comes with a word address. The block clears the in-line offset bits of that address and then issues sixteen single-word reads. Word k of the line goes to bank k mod 4. A bank answers a fixed number of cycles after it is asked, and it cannot take a second read while one is in flight. In interleaved mode the block asks a new bank every cycle, so the bank latencies overlap and a line arrives in 19 cycles.

Every word that comes back is passed straight through, in the cycle it arrives, to two places: the cache fill port, where it is tagged with its word offset, and the processor data port. A mode input, sampled when a fetch is accepted, selects a fully serial fetch instead. In serial mode each read starts only when the one before it has finished, so a line takes 64 cycles. The banks themselves sit outside the block.

Top module: `ilv_line_fetch`

## Requirements
- R1: Word k of a line (k = 0..15) is requested from bank k mod 4 by raising bit (k mod 4) of the one-hot request vector. The shared address bus carries the line base plus k in that cycle, and at most one request bit is high in any cycle.
- R2: The low 4 bits of the start address are ignored, so the line base is the start address with those bits forced to zero.
- R3: Call the cycle right after the clock edge that accepts start cycle 0. In interleaved mode, word k is requested in cycle k.
- R4: In interleaved mode, word k reaches the fill port in cycle k+4, so the last word arrives in cycle 19.
- R5: In serial mode, word k is requested in cycle 4k and delivered in cycle 4k+4, so the last word arrives in cycle 64.
- R6: Each delivered word carries its word offset k on the offset output and the data word the bank returned. The processor port shows the same data with its valid flag raised in the same cycle.
- R7: Busy is high from cycle 0 through the cycle of the last delivery. Done is high for exactly the next cycle, with busy low in that cycle, and both are low after reset.
- R8: A start pulse that arrives while busy is high has no effect: the request schedule, the addresses and the deliveries of the running fetch are unchanged, and no new fetch begins.
- R9: A bank gets no new request until its previous access has run its full latency. If the next bank in the rotation is still busy, issue stalls: with a 6-cycle latency, word k is requested in cycle 6*(k/4) + (k mod 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for one line fetch |
| seq_mode_i | input | 1 | 1 selects serial fetch, 0 selects interleaved; sampled when start is accepted |
| line_addr_i | input | ADDR_W | Word address of the line; offset bits are ignored |
| busy_o | output | 1 | Fetch in progress |
| done_o | output | 1 | One-cycle pulse after the last word |
| bank_req_o | output | NUM_BANKS | One-hot read request, one bit per bank |
| bank_addr_o | output | ADDR_W | Word address of the current request |
| bank_rvalid_i | input | NUM_BANKS | Per-bank return strobe |
| bank_rdata_i | input | NUM_BANKS*DATA_W | Per-bank return data; bank b occupies bits b*DATA_W and up |
| fill_valid_o | output | 1 | Cache fill word valid |
| fill_offset_o | output | log2(LINE_WORDS) | Word position of the fill word in the line |
| fill_data_o | output | DATA_W | Cache fill data |
| cpu_valid_o | output | 1 | Processor data valid |
| cpu_data_o | output | DATA_W | Processor data |

## Verification
Each request is due in its computed issue cycle. The bench derives that cycle itself from the bank-free times and the mode (cycle k interleaved, 4k serial, stalled rotation for the slower banks). The matching delivery is due exactly one bank latency later, busy holds up to that last delivery, and done follows one cycle after it. The bench counts cycles from the edge that accepts start, and at every falling edge it compares requests, address, fill, processor port, busy and done with that schedule. Stray start pulses are placed in the middle of a fetch and in its final delivery cycle, so the unchanged schedule shows that they were ignored.

// File: rtl/ilvf_pkg.sv
package ilvf_pkg;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_RUN  = 2'd1,
    FS_DONE = 2'd2
  } fetch_state_e;

  // A word may issue when the fetch is active and its bank is free.
  // Serial mode also waits until every bank has gone quiet.
  function automatic logic issue_allowed(input logic active,
                                         input logic tgt_free,
                                         input logic all_free,
                                         input logic serial);
    return active && tgt_free && (!serial || all_free);
  endfunction

  // Timer value loaded on a request; reaches zero when the bank frees.
  function automatic int unsigned busy_reload(input int unsigned lat);
    return (lat > 0) ? lat - 1 : 0;
  endfunction

endpackage

// File: rtl/ilvf_issue.sv
module ilvf_issue
  import ilvf_pkg::*;
#(
  parameter int NB     = 4,
  parameter int LAT    = 4,
  parameter int LW     = 16,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic              serial_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [NB-1:0]     req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fire_o
);
  localparam int BW = (NB > 1) ? $clog2(NB) : 1;
  localparam int OW = $clog2(LW);
  localparam int CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] RELOAD = CW'(busy_reload(LAT));

  logic [OW-1:0] idx_q;
  logic          active_q;
  logic [CW-1:0] cnt_q [NB];
  logic [NB-1:0] free_w;
  logic [BW-1:0] tgt_w;

  assign tgt_w  = BW'(idx_q % OW'(NB));
  assign fire_o = issue_allowed(active_q, free_w[tgt_w], &free_w, serial_i);

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_bank
      assign free_w[b] = (cnt_q[b] == '0);
      assign req_o[b]  = fire_o && (tgt_w == BW'(b));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q[b] <= '0;
        end else if (req_o[b]) begin
          cnt_q[b] <= RELOAD;
        end else if (!free_w[b]) begin
          cnt_q[b] <= cnt_q[b] - CW'(1);
        end
      end
    end
  endgenerate

  assign addr_o = base_i | ADDR_W'(idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      active_q <= 1'b0;
    end else if (launch_i) begin
      idx_q    <= '0;
      active_q <= 1'b1;
    end else if (fire_o) begin
      idx_q <= idx_q + OW'(1);
      if (idx_q == OW'(LW - 1)) begin
        active_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ilvf_collect.sv
module ilvf_collect #(
  parameter int NB = 4,
  parameter int LW = 16,
  parameter int DW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           launch_i,
  input  logic           active_i,
  input  logic [NB-1:0]  rvalid_i,
  input  logic [NB*DW-1:0] rdata_i,
  output logic           hit_o,
  output logic [$clog2(LW)-1:0] offset_o,
  output logic [DW-1:0]  data_o,
  output logic           last_o
);
  localparam int BW = (NB > 1) ? $clog2(NB) : 1;
  localparam int OW = $clog2(LW);

  logic [OW-1:0] rcv_q;
  logic [BW-1:0] expb_w;
  logic [DW-1:0] lane_w [NB];

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_lane
      assign lane_w[b] = rdata_i[b*DW +: DW];
    end
  endgenerate

  assign expb_w   = BW'(rcv_q % OW'(NB));
  assign hit_o    = active_i && rvalid_i[expb_w];
  assign data_o   = lane_w[expb_w];
  assign offset_o = rcv_q;
  assign last_o   = hit_o && (rcv_q == OW'(LW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcv_q <= '0;
    end else if (launch_i) begin
      rcv_q <= '0;
    end else if (hit_o) begin
      rcv_q <= rcv_q + OW'(1);
    end
  end

endmodule

// File: rtl/ilv_line_fetch.sv
module ilv_line_fetch
  import ilvf_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_LAT   = 4,
  parameter int LINE_WORDS = 16,
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic                          seq_mode_i,
  input  logic [ADDR_W-1:0]             line_addr_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [NUM_BANKS-1:0]          bank_req_o,
  output logic [ADDR_W-1:0]             bank_addr_o,
  input  logic [NUM_BANKS-1:0]          bank_rvalid_i,
  input  logic [NUM_BANKS*DATA_W-1:0]   bank_rdata_i,
  output logic                          fill_valid_o,
  output logic [$clog2(LINE_WORDS)-1:0] fill_offset_o,
  output logic [DATA_W-1:0]             fill_data_o,
  output logic                          cpu_valid_o,
  output logic [DATA_W-1:0]             cpu_data_o
);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(LINE_WORDS - 1);

  fetch_state_e      state_q, state_d;
  logic              seq_q;
  logic [ADDR_W-1:0] base_q;

  // Named internal events, observed by the bound checker.
  logic              launch_w;
  logic              issue_fire_w;
  logic              last_word_w;
  logic              hit_w;
  logic [OFF_W-1:0]  off_w;
  logic [DATA_W-1:0] word_w;

  assign launch_w = start_i && (state_q != FS_RUN);

  always_comb begin
    state_d = state_q;
    case (state_q)
      FS_IDLE: if (launch_w) state_d = FS_RUN;
      FS_RUN:  if (last_word_w) state_d = FS_DONE;
      FS_DONE: state_d = launch_w ? FS_RUN : FS_IDLE;
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      seq_q   <= 1'b0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      if (launch_w) begin
        seq_q  <= seq_mode_i;
        base_q <= line_addr_i & ~OFF_MASK;
      end
    end
  end

  assign busy_o = (state_q == FS_RUN);
  assign done_o = (state_q == FS_DONE);

  ilvf_issue #(
    .NB(NUM_BANKS), .LAT(BANK_LAT), .LW(LINE_WORDS), .ADDR_W(ADDR_W)
  ) u_issue (
    .clk(clk), .rst_n(rst_n),
    .launch_i(launch_w), .serial_i(seq_q), .base_i(base_q),
    .req_o(bank_req_o), .addr_o(bank_addr_o), .fire_o(issue_fire_w)
  );

  ilvf_collect #(
    .NB(NUM_BANKS), .LW(LINE_WORDS), .DW(DATA_W)
  ) u_collect (
    .clk(clk), .rst_n(rst_n),
    .launch_i(launch_w), .active_i(busy_o),
    .rvalid_i(bank_rvalid_i), .rdata_i(bank_rdata_i),
    .hit_o(hit_w), .offset_o(off_w), .data_o(word_w), .last_o(last_word_w)
  );

  assign fill_valid_o  = hit_w;
  assign fill_offset_o = off_w;
  assign fill_data_o   = word_w;
  assign cpu_valid_o   = hit_w;
  assign cpu_data_o    = word_w;

endmodule

// File: rtl/ilvf_checker.sv
module ilvf_checker #(
  parameter int NB = 4,
  parameter int LW = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_i,
  input logic                  busy_o,
  input logic                  done_o,
  input logic [NB-1:0]         bank_req_o,
  input logic                  fill_valid_o,
  input logic [$clog2(LW)-1:0] fill_offset_o,
  input logic                  launch_w,
  input logic                  issue_fire_w,
  input logic                  last_word_w
);
  localparam int OW = $clog2(LW);

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_req_o)); // R1

  AST_FIRE_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire_w |-> ($countones(bank_req_o) == 1)); // R1

  AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_req_o) |-> busy_o); // R7

  AST_FILL_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid_o |-> busy_o); // R4

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_word_w |=> (done_o && !busy_o)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_DONE_LAST_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(fill_offset_o) == OW'(LW - 1))); // R6

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !last_word_w) |=> busy_o); // R8

  AST_LAUNCH_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    launch_w |-> !busy_o); // R8

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_space
      AST_BANK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        bank_req_o[b] |=> !bank_req_o[b]); // R9
    end
  endgenerate

endmodule

bind ilv_line_fetch ilvf_checker #(
  .NB(NUM_BANKS), .LW(LINE_WORDS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .bank_req_o(bank_req_o),
  .fill_valid_o(fill_valid_o), .fill_offset_o(fill_offset_o),
  .launch_w(launch_w), .issue_fire_w(issue_fire_w), .last_word_w(last_word_w)
);

// File: tb/ilvf_bank_model.sv
module ilvf_bank_model #(
  parameter int NB  = 4,
  parameter int LAT = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NB-1:0]  req_i,
  input  logic [23:0]    addr_i,
  output logic [NB-1:0]  rvalid_o,
  output logic [NB*32-1:0] rdata_o
);
  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_bank
      logic        vld [LAT];
      logic [23:0] adr [LAT];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < LAT; s++) begin
            vld[s] <= 1'b0;
            adr[s] <= '0;
          end
        end else begin
          vld[0] <= req_i[b];
          adr[0] <= addr_i;
          for (int s = 1; s < LAT; s++) begin
            vld[s] <= vld[s-1];
            adr[s] <= adr[s-1];
          end
        end
      end
      assign rvalid_o[b]        = vld[LAT-1];
      assign rdata_o[b*32 +: 32] = {8'hC3, adr[LAT-1] ^ 24'h5A3C0F};
    end
  endgenerate
endmodule

// File: tb/ilv_line_fetch_tb.sv
`timescale 1ns/1ps
module ilv_line_fetch_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seq_mode = 1'b0;
  logic [23:0] line_addr = '0;
  logic start_a = 1'b0, start_b = 1'b0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  logic busy_a, done_a, fv_a, cv_a; logic [3:0] req_a, rv_a, fo_a;
  logic [23:0] addr_a; logic [127:0] rd_a; logic [31:0] fd_a, cd_a;
  logic busy_b, done_b, fv_b, cv_b; logic [3:0] req_b, rv_b, fo_b;
  logic [23:0] addr_b; logic [127:0] rd_b; logic [31:0] fd_b, cd_b;

  ilv_line_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_a), .seq_mode_i(seq_mode),
    .line_addr_i(line_addr), .busy_o(busy_a), .done_o(done_a),
    .bank_req_o(req_a), .bank_addr_o(addr_a), .bank_rvalid_i(rv_a),
    .bank_rdata_i(rd_a), .fill_valid_o(fv_a), .fill_offset_o(fo_a),
    .fill_data_o(fd_a), .cpu_valid_o(cv_a), .cpu_data_o(cd_a));
  ilvf_bank_model #(.NB(4), .LAT(4)) u_mem_a (
    .clk(clk), .rst_n(rst_n), .req_i(req_a), .addr_i(addr_a),
    .rvalid_o(rv_a), .rdata_o(rd_a));

  ilv_line_fetch #(.BANK_LAT(6)) u_dut6 (
    .clk(clk), .rst_n(rst_n), .start_i(start_b), .seq_mode_i(seq_mode),
    .line_addr_i(line_addr), .busy_o(busy_b), .done_o(done_b),
    .bank_req_o(req_b), .bank_addr_o(addr_b), .bank_rvalid_i(rv_b),
    .bank_rdata_i(rd_b), .fill_valid_o(fv_b), .fill_offset_o(fo_b),
    .fill_data_o(fd_b), .cpu_valid_o(cv_b), .cpu_data_o(cd_b));
  ilvf_bank_model #(.NB(4), .LAT(6)) u_mem_b (
    .clk(clk), .rst_n(rst_n), .req_i(req_b), .addr_i(addr_b),
    .rvalid_o(rv_b), .rdata_o(rd_b));

  logic slow = 1'b0;
  logic o_busy, o_done, o_fv, o_cv; logic [3:0] o_req, o_fo;
  logic [23:0] o_addr; logic [31:0] o_fd, o_cd;
  always_comb begin
    o_busy = slow ? busy_b : busy_a;  o_done = slow ? done_b : done_a;
    o_req  = slow ? req_b  : req_a;   o_addr = slow ? addr_b : addr_a;
    o_fv   = slow ? fv_b   : fv_a;    o_fo   = slow ? fo_b   : fo_a;
    o_fd   = slow ? fd_b   : fd_a;    o_cv   = slow ? cv_b   : cv_a;
    o_cd   = slow ? cd_b   : cd_a;
  end

  function automatic logic [31:0] word_of(input logic [23:0] a);
    return {8'hC3, a ^ 24'h5A3C0F};
  endfunction

  task automatic chk(input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic drive_start(input logic v);
    if (slow) start_b = v; else start_a = v;
  endtask

  // One line fetch, checked cycle by cycle against a schedule built here.
  task automatic run_fetch(input logic use_slow, input logic [23:0] addr,
                           input logic ser, input int intrude,
                           input string t_req, input string t_fill,
                           input string t_addr);
    int iss[16]; int freeb[4]; int lat; int lastf;
    logic [23:0] base;
    slow = use_slow;
    lat  = use_slow ? 6 : 4;
    base = {addr[23:4], 4'h0};
    for (int b = 0; b < 4; b++) freeb[b] = 0;
    for (int k = 0; k < 16; k++) begin
      int t;
      if (k == 0) t = 0;
      else t = ser ? iss[k-1] + lat : iss[k-1] + 1;
      if (t < freeb[k % 4]) t = freeb[k % 4];
      iss[k] = t;
      freeb[k % 4] = t + lat;
    end
    lastf = iss[15] + lat;

    @(negedge clk);
    seq_mode  = ser;
    line_addr = addr;
    drive_start(1'b1);
    @(negedge clk);
    drive_start(1'b0);
    seq_mode  = ~ser;          // mode is latched; a later change must not matter
    line_addr = ~addr;
    for (int t = 0; t <= lastf + 2; t++) begin
      logic [3:0] ereq; logic [23:0] eaddr; logic efv; logic [3:0] efo;
      string rtag;
      ereq = '0; eaddr = '0; efv = 1'b0; efo = '0;
      for (int k = 0; k < 16; k++) begin
        if (iss[k] == t) begin ereq = 4'(1 << (k % 4)); eaddr = base + 24'(k); end
        if (iss[k] + lat == t) begin efv = 1'b1; efo = 4'(k); end
      end
      rtag = (intrude >= 0 && t > intrude) ? "R8" : t_req;
      chk(rtag, "request vector", o_req, ereq);
      if (ereq != 0) chk(t_addr, "request address", o_addr, eaddr);
      chk((intrude >= 0 && t > intrude) ? "R8" : t_fill, "fill valid", o_fv, efv);
      if (efv) begin
        chk("R6", "fill offset", o_fo, efo);
        chk("R6", "fill data", o_fd, word_of(base + 24'(efo)));
        chk("R6", "cpu valid", o_cv, 1);
        chk("R6", "cpu data", o_cd, word_of(base + 24'(efo)));
      end else begin
        chk("R6", "cpu valid idle", o_cv, 0);
      end
      chk("R7", "busy", o_busy, (t <= lastf) ? 1 : 0);
      chk("R7", "done", o_done, (t == lastf + 1) ? 1 : 0);
      drive_start(t == intrude);
      @(negedge clk);
    end
    drive_start(1'b0);
    chk((intrude >= 0) ? "R8" : "R7", "idle after fetch", o_busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R7", "reset busy", busy_a, 0);
    chk("R7", "reset done", done_a, 0);
    chk("R1", "reset request", req_a, 0);
    chk("R4", "reset fill", fv_a, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7", "idle busy", busy_b | busy_a, 0);

    run_fetch(0, 24'h1F6A10, 0, -1, "R3", "R4", "R1");
    run_fetch(0, 24'h000000, 0,  5, "R3", "R4", "R1");
    run_fetch(0, 24'hFFFFF0, 1, 10, "R5", "R5", "R1");
    run_fetch(0, 24'h12345F, 0, 19, "R3", "R4", "R2");
    run_fetch(0, 24'h0ABCD7, 1, 64, "R5", "R5", "R2");
    run_fetch(1, 24'h1F6A10, 0, -1, "R9", "R9", "R1");
    run_fetch(1, 24'h54321A, 1, 30, "R9", "R9", "R2");
    run_fetch(1, 24'h777770, 0,  7, "R9", "R9", "R1");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule